// File: doc/BRIEF.md
# Multiplexed Latching Bus Exchanger

This block lets two 12-bit data paths share a single 12-bit path. One side is the shared port A. The other side has two bank ports, B1 and B2. A value on A can be captured into either of two outbound latches, and each of those latches feeds its own bank. In the return direction, each bank captures its input into its own return latch, and a bank-select input decides which return latch appears on A. Typical uses are folding address and data onto one bus and interleaving two memory banks.

Each storage element is a level-sensitive latch. It passes its input while its enable is high and keeps the last value when the enable falls. Bidirectional pins are split into an input, an output value and a single drive-enable per port. Each port has its own active-low output enable. In the A-to-B direction, the two bank output enables work as bank controls. An asynchronous active-low reset empties every latch and holds all drive-enables off, so the bus stays floating at power-up.

Top module: `mlbx_top`

## Requirements
- R1: While rstN is low, aDrvEn, b1DrvEn and b2DrvEn are 0 and all four latches are zero, whatever the latch enables do. After release, an enabled port with a closed latch outputs zero.
- R2: While a latch enable is high, that latch is transparent. b1Out follows aIn under leToB1, b2Out follows aIn under leToB2, and aOut follows the selected bank input under its return enable.
- R3: When a latch enable falls, the latch keeps the value present just before the fall, and later input changes do not alter it.
- R4: The outbound latches for B1 and B2 capture A at different times and hold different values independently.
- R5: The return latches for B1 and B2 capture their own bank inputs independently.
- R6: aOut shows the B1 return latch when selB1 is 1 and the B2 return latch when selB1 is 0.
- R7: Out of reset, each drive-enable is 1 exactly when its active-low output enable (oeAN, oeB1N, oeB2N) is 0.
- R8: All four combinations of oeB1N and oeB2N (both banks, either bank alone, neither) give the matching drive-enables. Output enables never change latch contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 12 | Value seen on shared port A |
| aOut | output | 12 | Value presented to port A |
| aDrvEn | output | 1 | Port A drive enable |
| b1In | input | 12 | Value seen on bank 1 |
| b1Out | output | 12 | Value presented to bank 1 |
| b1DrvEn | output | 1 | Bank 1 drive enable |
| b2In | input | 12 | Value seen on bank 2 |
| b2Out | output | 12 | Value presented to bank 2 |
| b2DrvEn | output | 1 | Bank 2 drive enable |
| leToB1 | input | 1 | Enable of the A-to-B1 latch |
| leToB2 | input | 1 | Enable of the A-to-B2 latch |
| leFromB1 | input | 1 | Enable of the B1 return latch |
| leFromB2 | input | 1 | Enable of the B2 return latch |
| oeAN | input | 1 | Port A output enable, active low |
| oeB1N | input | 1 | Bank 1 output enable, active low |
| oeB2N | input | 1 | Bank 2 output enable, active low |
| selB1 | input | 1 | Return select: 1 picks bank 1, 0 picks bank 2 |

## Verification
The bench changes the input data right after a latch enable falls. A latch that behaved as a flop, or that kept tracking its input, would then show the new value instead of the held one. It loads the two outbound latches with different A values at different times, so crossed or shared enables would show up as equal bank outputs. It flips selB1 with different contents in the two return latches, which exposes an inverted select. It also asserts reset with every latch enable high, which catches a clear that loses to a transparent enable and drive-enables that ignore reset.

// File: rtl/mlbx_pkg.sv
package mlbx_pkg;
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic                 clear;
    logic [NUM_BANKS-1:0] capToB;
    logic [NUM_BANKS-1:0] capFromB;
    logic                 drvA;
    logic [NUM_BANKS-1:0] drvB;
    logic                 pickB1;
  } mlbx_strobe_t;
endpackage

// File: rtl/mlbx_latch.sv
module mlbx_latch #(
  parameter int WIDTH = 12
) (
  input  logic             clear,
  input  logic             open,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Clear wins over an open enable so reset leaves storage at zero.
  always_latch begin
    if (clear)     q = '0;
    else if (open) q = d;
  end
endmodule

// File: rtl/mlbx_ctrl.sv
module mlbx_ctrl
  import mlbx_pkg::*;
(
  input  logic         rstN,
  input  logic         leToB1,
  input  logic         leToB2,
  input  logic         leFromB1,
  input  logic         leFromB2,
  input  logic         oeAN,
  input  logic         oeB1N,
  input  logic         oeB2N,
  input  logic         selB1,
  output mlbx_strobe_t strobe
);
  always_comb begin
    strobe.clear       = ~rstN;
    strobe.capToB[0]   = rstN & leToB1;
    strobe.capToB[1]   = rstN & leToB2;
    strobe.capFromB[0] = rstN & leFromB1;
    strobe.capFromB[1] = rstN & leFromB2;
    strobe.drvA        = rstN & ~oeAN;
    strobe.drvB[0]     = rstN & ~oeB1N;
    strobe.drvB[1]     = rstN & ~oeB2N;
    strobe.pickB1      = selB1;
  end
endmodule

// File: rtl/mlbx_datapath.sv
module mlbx_datapath
  import mlbx_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  mlbx_strobe_t                   strobe,
  input  logic [WIDTH-1:0]               aIn,
  input  logic [NUM_BANKS-1:0][WIDTH-1:0] bIn,
  output logic [WIDTH-1:0]               aOut,
  output logic [NUM_BANKS-1:0][WIDTH-1:0] bOut
);
  logic [NUM_BANKS-1:0][WIDTH-1:0] retQ;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    mlbx_latch #(.WIDTH(WIDTH)) uToB (
      .clear(strobe.clear),
      .open (strobe.capToB[g]),
      .d    (aIn),
      .q    (bOut[g])
    );
    mlbx_latch #(.WIDTH(WIDTH)) uFromB (
      .clear(strobe.clear),
      .open (strobe.capFromB[g]),
      .d    (bIn[g]),
      .q    (retQ[g])
    );
  end

  assign aOut = strobe.pickB1 ? retQ[0] : retQ[1];
endmodule

// File: rtl/mlbx_top.sv
module mlbx_top
  import mlbx_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrvEn,
  input  logic [WIDTH-1:0] b1In,
  output logic [WIDTH-1:0] b1Out,
  output logic             b1DrvEn,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] b2Out,
  output logic             b2DrvEn,
  input  logic             leToB1,
  input  logic             leToB2,
  input  logic             leFromB1,
  input  logic             leFromB2,
  input  logic             oeAN,
  input  logic             oeB1N,
  input  logic             oeB2N,
  input  logic             selB1
);
  mlbx_strobe_t                    strobe;
  logic [NUM_BANKS-1:0][WIDTH-1:0] bInBus;
  logic [NUM_BANKS-1:0][WIDTH-1:0] bOutBus;

  assign bInBus[0] = b1In;
  assign bInBus[1] = b2In;

  mlbx_ctrl uCtrl (
    .rstN    (rstN),
    .leToB1  (leToB1),
    .leToB2  (leToB2),
    .leFromB1(leFromB1),
    .leFromB2(leFromB2),
    .oeAN    (oeAN),
    .oeB1N   (oeB1N),
    .oeB2N   (oeB2N),
    .selB1   (selB1),
    .strobe  (strobe)
  );

  mlbx_datapath #(.WIDTH(WIDTH)) uData (
    .strobe(strobe),
    .aIn   (aIn),
    .bIn   (bInBus),
    .aOut  (aOut),
    .bOut  (bOutBus)
  );

  assign b1Out   = bOutBus[0];
  assign b2Out   = bOutBus[1];
  assign aDrvEn  = strobe.drvA;
  assign b1DrvEn = strobe.drvB[0];
  assign b2DrvEn = strobe.drvB[1];
endmodule

// File: rtl/mlbx_checks.sv
module mlbx_checks #(
  parameter int WIDTH = 12
) (
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrvEn,
  input logic [WIDTH-1:0] b1In,
  input logic [WIDTH-1:0] b1Out,
  input logic             b1DrvEn,
  input logic [WIDTH-1:0] b2In,
  input logic [WIDTH-1:0] b2Out,
  input logic             b2DrvEn,
  input logic             leToB1,
  input logic             leToB2,
  input logic             leFromB1,
  input logic             leFromB2,
  input logic             oeAN,
  input logic             oeB1N,
  input logic             oeB2N,
  input logic             selB1
);
  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!aDrvEn && !b1DrvEn && !b2DrvEn)
        else $error("drive enabled during reset");
      assert_reset_empty_R1: assert (aOut == '0 && b1Out == '0 && b2Out == '0)
        else $error("latch not cleared during reset");
    end
    if (rstN) begin
      assert_oe_a_R7: assert (aDrvEn == !oeAN) else $error("A drive mismatch");
      assert_oe_banks_R8: assert (b1DrvEn == !oeB1N && b2DrvEn == !oeB2N)
        else $error("bank drive mismatch");
    end
    if (rstN && leToB1) begin
      assert_follow_b1_R2: assert (b1Out == aIn) else $error("B1 not transparent");
    end
    if (rstN && leToB2) begin
      assert_follow_b2_R2: assert (b2Out == aIn) else $error("B2 not transparent");
    end
    if (rstN && leFromB1 && selB1) begin
      assert_select_b1_R6: assert (aOut == b1In) else $error("select B1 wrong");
    end
    if (rstN && leFromB2 && !selB1) begin
      assert_select_b2_R6: assert (aOut == b2In) else $error("select B2 wrong");
    end
  end
endmodule

bind mlbx_top mlbx_checks #(.WIDTH(WIDTH)) uChecks (
  .rstN(rstN), .aIn(aIn), .aOut(aOut), .aDrvEn(aDrvEn),
  .b1In(b1In), .b1Out(b1Out), .b1DrvEn(b1DrvEn),
  .b2In(b2In), .b2Out(b2Out), .b2DrvEn(b2DrvEn),
  .leToB1(leToB1), .leToB2(leToB2), .leFromB1(leFromB1), .leFromB2(leFromB2),
  .oeAN(oeAN), .oeB1N(oeB1N), .oeB2N(oeB2N), .selB1(selB1)
);

// File: tb/tb_mlbx_top.sv
`timescale 1ns/100ps
module tb_mlbx_top;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [W-1:0] aIn, b1In, b2In, aOut, b1Out, b2Out;
  logic aDrvEn, b1DrvEn, b2DrvEn;
  logic leToB1, leToB2, leFromB1, leFromB2, oeAN, oeB1N, oeB2N, selB1;

  mlbx_top #(.WIDTH(W)) dut (
    .rstN(rstN), .aIn(aIn), .aOut(aOut), .aDrvEn(aDrvEn),
    .b1In(b1In), .b1Out(b1Out), .b1DrvEn(b1DrvEn),
    .b2In(b2In), .b2Out(b2Out), .b2DrvEn(b2DrvEn),
    .leToB1(leToB1), .leToB2(leToB2), .leFromB1(leFromB1), .leFromB2(leFromB2),
    .oeAN(oeAN), .oeB1N(oeB1N), .oeB2N(oeB2N), .selB1(selB1)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit reported = 1'b0;

  // Behavioural reference: four stored integers updated from the pins.
  int mToB1, mToB2, mFromB1, mFromB2;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  // Reference model update and comparison every cycle, away from the drive edge.
  always @(negedge clk) begin
    if (!rstN) begin
      mToB1 = 0; mToB2 = 0; mFromB1 = 0; mFromB2 = 0;
    end else begin
      if (leToB1)   mToB1   = int'(aIn);
      if (leToB2)   mToB2   = int'(aIn);
      if (leFromB1) mFromB1 = int'(b1In);
      if (leFromB2) mFromB2 = int'(b2In);
    end
    check("R2 b1Out", int'(b1Out), mToB1);
    check("R2 b2Out", int'(b2Out), mToB2);
    check("R6 aOut", int'(aOut), selB1 ? mFromB1 : mFromB2);
    check("R7 aDrvEn", int'(aDrvEn), int'(rstN && !oeAN));
    check("R8 b1DrvEn", int'(b1DrvEn), int'(rstN && !oeB1N));
    check("R8 b2DrvEn", int'(b2DrvEn), int'(rstN && !oeB2N));
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
  endtask

  task automatic probe();
    @(negedge clk); #0.5;
  endtask

  initial begin
    rstN = 1'b0; aIn = 12'h7E1; b1In = 12'h3C3; b2In = 12'h99A;
    leToB1 = 1'b1; leToB2 = 1'b1; leFromB1 = 1'b1; leFromB2 = 1'b1;
    oeAN = 1'b0; oeB1N = 1'b0; oeB2N = 1'b0; selB1 = 1'b1;
    probe();
    // R1: reset wins over open latches and blocks every drive
    check("R1 drv", int'({aDrvEn, b1DrvEn, b2DrvEn}), 0);
    check("R1 b1", int'(b1Out), 0);
    check("R1 a", int'(aOut), 0);
    tick(); leToB1 = 0; leToB2 = 0; leFromB1 = 0; leFromB2 = 0;
    tick(); rstN = 1'b1;
    probe();
    check("R1 empty after release", int'({aOut, b1Out, b2Out}), 0);
    check("R7 drive on", int'({aDrvEn, b1DrvEn, b2DrvEn}), 3'b111);

    // R2 / R3 / R4 on the outbound side
    tick(); aIn = 12'h5A5; leToB1 = 1;
    probe(); check("R2 transparent b1", int'(b1Out), 'h5A5);
    tick(); leToB1 = 0;
    tick(); aIn = 12'h0F0;
    probe(); check("R3 hold b1", int'(b1Out), 'h5A5);
    tick(); leToB2 = 1;
    tick(); leToB2 = 0;
    tick(); aIn = 12'hFFF;
    probe();
    check("R4 b2 own value", int'(b2Out), 'h0F0);
    check("R4 b1 untouched", int'(b1Out), 'h5A5);

    // R5 / R6 on the return side
    tick(); b1In = 12'h123; leFromB1 = 1;
    tick(); leFromB1 = 0;
    tick(); b1In = 12'h000; b2In = 12'hABC; leFromB2 = 1;
    tick(); leFromB2 = 0;
    tick(); b2In = 12'h111;
    probe(); check("R6 select B1", int'(aOut), 'h123);
    tick(); selB1 = 0;
    probe(); check("R5 B2 return held", int'(aOut), 'hABC);
    tick(); selB1 = 1;
    probe(); check("R5 B1 return held", int'(aOut), 'h123);

    // R8: all bank-control combinations; contents must survive
    for (int k = 0; k < 4; k++) begin
      tick(); oeB1N = k[0]; oeB2N = k[1];
      probe();
      check("R8 bank drive", int'({b1DrvEn, b2DrvEn}), int'({!k[0], !k[1]}));
    end
    tick(); oeAN = 1;
    probe(); check("R7 A floats", int'(aDrvEn), 0);
    tick(); oeAN = 0; oeB1N = 0; oeB2N = 0;
    probe();
    check("R8 contents kept b1", int'(b1Out), 'h5A5);
    check("R8 contents kept b2", int'(b2Out), 'h0F0);
    check("R8 contents kept a", int'(aOut), 'h123);

    // R1: reset in the middle of traffic
    tick(); rstN = 0;
    probe();
    check("R1 mid-run drive", int'({aDrvEn, b1DrvEn, b2DrvEn}), 0);
    check("R1 mid-run clear", int'({b1Out, b2Out}), 0);
    tick(); rstN = 1;
    tick(2);
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      report();
      $finish;
    end
  end
endmodule